// File: doc/BRIEF.md
# Codec Clock-Activity Power Controller

This block chooses the operating state of a voice codec's digital section. It runs from a free-running reference clock. It samples three asynchronous inputs: an active-low shutdown request, the serial bit clock and the transmit frame strobe. Each input passes through a synchronizer. When the shutdown request is asserted, the block selects the power-down state. When either clock-like input stops toggling for a programmable number of reference cycles, the block drops to power-save. Otherwise the codec may run. The stop can happen at either logic level.

Leaving power-save is deliberately slow. The block measures the frame strobe period from one rising edge to the next. It returns to operation only after a programmable number of consecutive periods fall inside the permitted window and both inputs are active. This prevents the codec from chattering between states on a marginal clock. Each measured period also updates a rate-error flag, so a frame rate outside the window is reported without stopping operation. Two enables tell the serial port and the converters when they may work. The serial output must be left undriven whenever the port enable is low.

Top module: `codec_power_mgr`

## Requirements
- R1: After synchronous reset, `mode` is 01 (power-save), `port_en` and `conv_en` are 0, and `rate_err` is 0.
- R2: A 0 on `shutdown_n` gives `mode` = 10 within 4 reference cycles, whatever the clock inputs do. When `shutdown_n` returns to 1, `mode` goes to 01 and never goes straight to 00.
- R3: If `bit_clk` shows no edge for `BCLK_IDLE` reference cycles, the block leaves operation for `mode` = 01. This holds whether the clock stopped high or low. Edges that come more often than that keep operation.
- R4: If `tx_frame` shows no edge for `SYNC_IDLE` reference cycles, the block leaves operation for `mode` = 01. This holds whether the strobe stopped high or low.
- R5: `port_en` and `conv_en` are 1 exactly when `mode` is 00. A low `port_en` means the serial data output is undriven.
- R6: `mode` moves from 01 to 00 only after `WAKE_FRAMES` consecutive in-range frame periods have been measured while neither input is stuck. The first rising edge of `tx_frame` after idle or reset only sets the timing reference.
- R7: An out-of-range frame period measured during that wake-up count restarts the count from zero.
- R8: A frame period is the number of reference cycles between successive rising edges of `tx_frame`. It is in range when `PER_MIN` <= period <= `PER_MAX`. At each measured period `rate_err` becomes 1 if the period is out of range and 0 if it is in range. Between measurements `rate_err` holds its value.
- R9: Out-of-range frame periods do not take the block out of operation (`mode` stays 00).
- R10: While `shutdown_n` is 0, `rate_err` is cleared and held at 0.
- R11: `mode` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown_n | input | 1 | Active-low power-down request (asynchronous) |
| bit_clk | input | 1 | Serial bit clock, watched for activity (asynchronous) |
| tx_frame | input | 1 | Transmit frame strobe, watched for activity and period (asynchronous) |
| mode | output | 2 | 00 operate, 01 power-save, 10 power-down |
| port_en | output | 1 | Serial port may drive its data output |
| conv_en | output | 1 | Converters enabled |
| rate_err | output | 1 | Last measured frame period was outside the window |

## Verification
The bench sweeps the frame period over every value from below `PER_MIN` to above `PER_MAX` while the block is operating. A design with an off-by-one window edge, or one that counted the period between the wrong edges, flags the boundary periods wrongly. A design that let a bad rate knock it out of operation shows up in the same sweep.

Stuck detection is exercised with each input frozen high and frozen low. Each time the bench checks both before and after the timeout. This catches a detector that only notices one level, or one that trips early on the long low phase of a slow strobe.

Wake-up is probed one frame before and one frame after the qualifying count, and again with a single bad period inserted partway through. A design that counts the reference edge as a period, or that does not restart the count after the bad period, wakes one frame early. Shutdown is applied while the clocks are also stuck and while bad frames arrive, so a design without strict priority, or one that lets the flag update during shutdown, is caught.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_SAVE = 2'b01,
        MODE_DOWN = 2'b10
    } pwr_mode_e;

    localparam int NUM_CHAN = 2;
    localparam int CH_BCLK  = 0;
    localparam int CH_FRAME = 1;

    typedef struct packed {
        logic level;
        logic toggled;
        logic rise;
        logic stuck;
    } chan_stat_t;

    typedef struct packed {
        logic valid;
        logic in_range;
    } frame_meas_t;

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[i] <= RST_VAL;
                else     pipe[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[i] <= RST_VAL;
                else     pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cpm_activity.sv
module cpm_activity
    import cpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 1600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    output chan_stat_t stat
);
    localparam int            CW  = cnt_width(IDLE_LIMIT);
    localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

    logic          lvl;
    logic          prev_q;
    logic [CW-1:0] idle_q;

    cpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            idle_q <= '0;
        end else begin
            prev_q <= lvl;
            if (lvl != prev_q)
                idle_q <= '0;
            else if (idle_q != LIM)
                idle_q <= idle_q + 1'b1;
        end
    end

    always_comb begin
        stat.level   = lvl;
        stat.toggled = lvl ^ prev_q;
        stat.rise    = lvl & ~prev_q;
        stat.stuck   = (idle_q == LIM);
    end
endmodule

// File: rtl/cpm_frame_meter.sv
module cpm_frame_meter
    import cpm_pkg::*;
#(
    parameter int PER_MIN = 5000,
    parameter int PER_MAX = 8334
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_ok,
    input  logic        rise,
    input  logic        stuck,
    output frame_meas_t meas,
    output logic        rate_err
);
    localparam int            CAP = PER_MAX + 1;
    localparam int            CW  = cnt_width(CAP);
    localparam logic [CW-1:0] CAP_V = CW'(CAP);
    localparam logic [CW-1:0] MIN_V = CW'(PER_MIN);
    localparam logic [CW-1:0] MAX_V = CW'(PER_MAX);

    logic [CW-1:0] per_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
        end else if (rise) begin
            per_q <= CW'(1);
        end else if (per_q != CAP_V) begin
            per_q <= per_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) armed_q <= 1'b0;
        else if (rise)      armed_q <= 1'b1;
        else if (stuck)     armed_q <= 1'b0;
    end

    always_comb begin
        meas.valid    = rise & armed_q & ~stuck;
        meas.in_range = (per_q >= MIN_V) && (per_q <= MAX_V);
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) rate_err <= 1'b0;
        else if (meas.valid) rate_err <= ~meas.in_range;
    end
endmodule

// File: rtl/cpm_mode_fsm.sv
module cpm_mode_fsm
    import cpm_pkg::*;
#(
    parameter int WAKE_FRAMES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_ok,
    input  logic        any_stuck,
    input  frame_meas_t meas,
    output pwr_mode_e   mode
);
    localparam int            WW     = cnt_width(WAKE_FRAMES);
    localparam logic [WW-1:0] WAKE_V = WW'(WAKE_FRAMES);

    pwr_mode_e     state_q, state_d;
    logic [WW-1:0] wake_q;
    logic          wake_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= '0;
        end else if (state_q != MODE_SAVE || any_stuck || !pwr_ok) begin
            wake_q <= '0;
        end else if (meas.valid) begin
            if (!meas.in_range)      wake_q <= '0;
            else if (wake_q != WAKE_V) wake_q <= wake_q + 1'b1;
        end
    end

    assign wake_ok = (wake_q == WAKE_V);

    always_comb begin
        state_d = state_q;
        if (!pwr_ok) begin
            state_d = MODE_DOWN;
        end else begin
            unique case (state_q)
                MODE_DOWN: state_d = MODE_SAVE;
                MODE_SAVE: if (wake_ok && !any_stuck) state_d = MODE_RUN;
                MODE_RUN:  if (any_stuck) state_d = MODE_SAVE;
                default:   state_d = MODE_SAVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_SAVE;
        else     state_q <= state_d;
    end

    assign mode = state_q;
endmodule

// File: rtl/codec_power_mgr.sv
module codec_power_mgr
    import cpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BCLK_IDLE   = 1600,
    parameter int SYNC_IDLE   = 20000,
    parameter int PER_MIN     = 5000,
    parameter int PER_MAX     = 8334,
    parameter int WAKE_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shutdown_n,
    input  logic       bit_clk,
    input  logic       tx_frame,
    output logic [1:0] mode,
    output logic       port_en,
    output logic       conv_en,
    output logic       rate_err
);
    logic [NUM_CHAN-1:0] raw_in;
    chan_stat_t          stat [NUM_CHAN];
    logic                pwr_ok;
    logic                any_stuck;
    logic                meas_valid;
    frame_meas_t         meas;
    pwr_mode_e           mode_q;

    assign raw_in[CH_BCLK]  = bit_clk;
    assign raw_in[CH_FRAME] = tx_frame;

    cpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pwr_sync (
        .clk (clk),
        .rst (rst),
        .d   (shutdown_n),
        .q   (pwr_ok)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        localparam int LIM = (ch == CH_BCLK) ? BCLK_IDLE : SYNC_IDLE;
        cpm_activity #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LIMIT(LIM)) u_act (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_in[ch]),
            .stat (stat[ch])
        );
    end

    assign any_stuck = stat[CH_BCLK].stuck | stat[CH_FRAME].stuck;

    cpm_frame_meter #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .pwr_ok   (pwr_ok),
        .rise     (stat[CH_FRAME].rise),
        .stuck    (stat[CH_FRAME].stuck),
        .meas     (meas),
        .rate_err (rate_err)
    );

    assign meas_valid = meas.valid;

    cpm_mode_fsm #(.WAKE_FRAMES(WAKE_FRAMES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .any_stuck (any_stuck),
        .meas      (meas),
        .mode      (mode_q)
    );

    assign mode    = mode_q;
    assign port_en = (mode_q == MODE_RUN);
    assign conv_en = (mode_q == MODE_RUN);
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_ok,
    input logic       any_stuck,
    input logic       meas_valid,
    input logic [1:0] mode,
    input logic       port_en,
    input logic       conv_en,
    input logic       rate_err
);
    a_r2_shutdown_forces_down: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> mode == 2'b10);

    // R3 and R4: a stuck input never allows operation on the next cycle
    a_r3_stuck_to_save: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && any_stuck) |=> mode == 2'b01);

    a_r6_run_only_from_save: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(mode) != 2'b00) |-> $past(mode) == 2'b01);

    a_r5_enables_in_run: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> (port_en && conv_en));

    a_r5_enables_off_else: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00) |-> (!port_en && !conv_en));

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && !meas_valid) |=> $stable(rate_err));

    a_r10_flag_cleared_down: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !rate_err);

    a_r11_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind codec_power_mgr cpm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_ok     (pwr_ok),
    .any_stuck  (any_stuck),
    .meas_valid (meas_valid),
    .mode       (mode),
    .port_en    (port_en),
    .conv_en    (conv_en),
    .rate_err   (rate_err)
);

// File: tb/tb_codec_power_mgr.sv
module tb_codec_power_mgr;
    localparam int BCLK_IDLE = 16;
    localparam int SYNC_IDLE = 100;
    localparam int PER_MIN   = 40;
    localparam int PER_MAX   = 60;
    localparam int WAKE      = 3;
    localparam int NOM       = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shutdown_n = 1'b1;
    logic       bit_clk = 1'b0;
    logic       tx_frame = 1'b0;
    logic [1:0] mode;
    logic       port_en, conv_en, rate_err;

    logic bclk_run  = 1'b1;
    logic bclk_hold = 1'b0;
    int   checks = 0;
    int   fails  = 0;
    logic done   = 1'b0;

    always #10 clk = ~clk;

    codec_power_mgr #(
        .SYNC_STAGES (2),
        .BCLK_IDLE   (BCLK_IDLE),
        .SYNC_IDLE   (SYNC_IDLE),
        .PER_MIN     (PER_MIN),
        .PER_MAX     (PER_MAX),
        .WAKE_FRAMES (WAKE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .shutdown_n (shutdown_n),
        .bit_clk    (bit_clk),
        .tx_frame   (tx_frame),
        .mode       (mode),
        .port_en    (port_en),
        .conv_en    (conv_en),
        .rate_err   (rate_err)
    );

    // bit clock: toggles every 2 reference cycles while running
    initial begin
        int half;
        half = 0;
        forever begin
            @(negedge clk);
            if (bclk_run) begin
                half = half + 1;
                if (half >= 2) begin
                    bit_clk = ~bit_clk;
                    half = 0;
                end
            end else begin
                bit_clk = bclk_hold;
                half = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frames(input int n, input int per);
        for (int k = 0; k < n; k++) begin
            tx_frame = 1'b1;
            repeat (4) @(negedge clk);
            tx_frame = 1'b0;
            repeat (per - 4) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 mode", mode, 1);
        check("R1 port_en", port_en, 0);
        check("R1 conv_en", conv_en, 0);
        check("R1 rate_err", rate_err, 0);

        // R6 wake-up after reset: first rise is reference only
        frames(WAKE, NOM);
        check("R6 before count", mode, 1);
        check("R5 port off in save", port_en, 0);
        frames(1, NOM);
        check("R6 after count", mode, 0);
        check("R5 port_en in run", port_en, 1);
        check("R5 conv_en in run", conv_en, 1);

        // R8 / R9 period sweep across the window
        for (int p = PER_MIN - 8; p <= PER_MAX + 8; p++) begin
            frames(3, p);
            check("R8 rate flag", rate_err, ((p < PER_MIN) || (p > PER_MAX)) ? 1 : 0);
            check("R9 stays in run", mode, 0);
        end
        frames(3, NOM);
        check("R8 flag clears", rate_err, 0);

        // R3 bit clock stuck at each level
        for (int lv = 0; lv < 2; lv++) begin
            bclk_hold = lv[0];
            bclk_run  = 1'b0;
            idle(8);
            check("R3 before timeout", mode, 0);
            idle(20);
            check("R3 stuck -> save", mode, 1);
            check("R5 port off", port_en, 0);
            bclk_run = 1'b1;
            frames(WAKE + 3, NOM);
            check("R3 recovery", mode, 0);
        end

        // R4 frame strobe stuck high
        tx_frame = 1'b1;
        idle(50);
        check("R4 high before timeout", mode, 0);
        idle(80);
        check("R4 high stuck -> save", mode, 1);
        frames(WAKE + 3, NOM);
        check("R4 recovery high", mode, 0);
        // R4 frame strobe stuck low
        idle(50);
        check("R4 low before timeout", mode, 0);
        idle(80);
        check("R4 low stuck -> save", mode, 1);

        // R7 bad period restarts wake count
        frames(WAKE - 1, NOM);
        frames(1, PER_MAX + 10);
        frames(WAKE, NOM);
        check("R7 count restarted", mode, 1);
        frames(1, NOM);
        check("R7 wake after restart", mode, 0);

        // R2 / R10 shutdown priority
        shutdown_n = 1'b0;
        idle(5);
        check("R2 shutdown -> down", mode, 2);
        check("R5 port off in down", port_en, 0);
        frames(2, PER_MAX + 10);
        check("R10 flag held low", rate_err, 0);
        bclk_hold = 1'b1;
        bclk_run  = 1'b0;
        idle(150);
        check("R2 down beats stuck", mode, 2);
        check("R11 no code 11", (mode == 2'b11) ? 1 : 0, 0);
        shutdown_n = 1'b1;
        bclk_run = 1'b1;
        idle(5);
        check("R2 release -> save", mode, 1);
        frames(WAKE + 1, NOM);
        check("R2 wake after release", mode, 0);
        check("R8 flag after release", rate_err, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule